// File: doc/BRIEF.md
# Quasi-Bidirectional Port Driver

This block controls a bank of general-purpose pins that have no direction register. Each pin keeps one stored output bit. A stored 0 turns on the pin's strong pull-down. A stored 1 leaves the pin on a weak pull-up, so an outside source can still pull the pin low, and the pin then works as an input. When a pin is written to 1, a strong pull-up is switched on for that pin so that the edge rises quickly. That boost ends at the next falling edge of the serial bus clock, which the bus front end reports as a one-cycle event.

The surrounding serial-bus logic gives a strobe when a full data byte has been received and acknowledged. It also gives a pulse for each falling SCL edge. The pad ring gives the raw pin levels. The block returns two enable vectors for the pad drivers, one for the strong pull-down and one for the strong pull-up. It also returns the pin levels after synchronisation, which the bus logic shifts out on a read.

Top module: `qb_port`

## Requirements
- R1: After reset every stored bit is 1. `driveLowEn` is all zeros, `strongUpEn` is all zeros and `pinValue` is all ones.
- R2: In the clock cycle after a cycle with `wrStrobe` high, `driveLowEn` equals the bitwise inverse of the `wrData` that was sampled. Bit i belongs to pin i.
- R3: In the cycle after a write, `strongUpEn` is 1 on exactly those pins whose written bit is 1.
- R4: In the cycle after `sclFall` is high while `wrStrobe` is low, `strongUpEn` is all zeros. `driveLowEn` does not change.
- R5: Writing a 1 to a pin whose stored bit is already 1 turns the strong pull-up on again for that pin.
- R6: No pin ever has `driveLowEn` and `strongUpEn` high at the same time.
- R7: `pinValue` follows `padIn` after SYNC_STAGES clock edges (2 by default). It does not depend on the stored bits, so a pin that is held low from outside reads 0 even when its stored bit is 1.
- R8: When `wrStrobe` and `sclFall` are high in the same cycle, the write takes effect. The new strong pull-up stays on until a later `sclFall`.
- R9: While `wrStrobe` is low, `wrData` has no effect on `driveLowEn` or `strongUpEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrData | input | WIDTH | Byte to store in the pins |
| wrStrobe | input | 1 | One-cycle pulse that loads `wrData` |
| sclFall | input | 1 | One-cycle pulse for each falling SCL edge |
| padIn | input | WIDTH | Raw pin levels from the pads |
| driveLowEn | output | WIDTH | Strong pull-down enable for each pin |
| strongUpEn | output | WIDTH | Transient strong pull-up enable for each pin |
| pinValue | output | WIDTH | Synchronised pin levels |

## Verification
The write path is tested with all-zeros, all-ones, the two alternating patterns and the two single-bit ends. These patterns show whether each bit lands on its own pin and whether the pull-down and the boost stay complementary. Each write is followed by a lone SCL fall, which shows that the boost ends and that the stored level is kept. The directed cases cover the following: a repeated 1-to-1 write, which tells a per-write pulse apart from an edge-detected one; a write that coincides with an SCL fall, which tells write priority apart from clear priority; data that changes without a strobe; and a read where the pad level differs from the stored bits, checked one edge early and then on time, which shows the synchroniser depth.

// File: rtl/qb_port_pkg.sv
package qb_port_pkg;
  // Strobes handed from the control to the datapath
  typedef struct packed {
    logic loadLatch;  // take a new byte and arm the boost on its ones
    logic dropBoost;  // end every active boost
  } qbStrobe_t;
endpackage

// File: rtl/qb_port_ctrl.sv
module qb_port_ctrl
  import qb_port_pkg::*;
(
  input  logic      wrStrobe,
  input  logic      sclFall,
  output qbStrobe_t strobes
);
  // A write that lands together with an SCL fall wins, so the fresh boost survives (R8)
  always_comb begin
    strobes.loadLatch = wrStrobe;
    strobes.dropBoost = sclFall & ~wrStrobe;
  end
endmodule

// File: rtl/qb_port_dp.sv
module qb_port_dp
  import qb_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  qbStrobe_t        strobes,
  input  logic [WIDTH-1:0] wrData,
  input  logic             sclFall,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] driveLowEn,
  output logic [WIDTH-1:0] strongUpEn,
  output logic [WIDTH-1:0] pinValue
);
  localparam logic [WIDTH-1:0] AllHigh = '1;
  localparam int LastStage = SYNC_STAGES - 1;

  logic [WIDTH-1:0] latchQ;
  logic [WIDTH-1:0] boostQ;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];

  // Stored pin levels, high at reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  latchQ <= AllHigh;
    else if (strobes.loadLatch) latchQ <= wrData;
  end

  // Transient boost: armed on every written one, cleared on SCL fall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  boostQ <= '0;
    else if (strobes.loadLatch) boostQ <= wrData;
    else if (strobes.dropBoost) boostQ <= '0;
  end

  // Pad level synchroniser
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= AllHigh;
        else if (s == 0) syncQ[s] <= padIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign driveLowEn = ~latchQ;
  assign strongUpEn = boostQ & latchQ;
  assign pinValue   = syncQ[LastStage];

  // R6: pull-down and boost are exclusive on every pin
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    (driveLowEn & strongUpEn) == '0);

  // R2: a write sets the pull-downs to the inverse of its data
  a_r2_drive: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadLatch |=> driveLowEn == ~$past(wrData));

  // R3: a write arms the boost exactly on its ones
  a_r3_boost: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadLatch |=> strongUpEn == $past(wrData));

  // R4: a lone SCL fall clears the boost and keeps the level
  a_r4_release: assert property (@(posedge clk) disable iff (!rstN)
    (sclFall && !strobes.loadLatch) |=> (strongUpEn == '0) && $stable(driveLowEn));

  // R9: no strobe, no change of the pull-downs
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadLatch |=> $stable(driveLowEn));
endmodule

// File: rtl/qb_port.sv
module qb_port
  import qb_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] wrData,
  input  logic             wrStrobe,
  input  logic             sclFall,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] driveLowEn,
  output logic [WIDTH-1:0] strongUpEn,
  output logic [WIDTH-1:0] pinValue
);
  qbStrobe_t strobes;

  qb_port_ctrl ctrl_i (
    .wrStrobe (wrStrobe),
    .sclFall  (sclFall),
    .strobes  (strobes)
  );

  qb_port_dp #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (wrData),
    .sclFall    (sclFall),
    .padIn      (padIn),
    .driveLowEn (driveLowEn),
    .strongUpEn (strongUpEn),
    .pinValue   (pinValue)
  );
endmodule

// File: tb/qb_port_tb_top.sv
`timescale 1ns/1ps
module qb_port_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       wrStrobe = 1'b0;
  logic       sclFall = 1'b0;
  logic [7:0] padIn = 8'hFF;
  logic [7:0] driveLowEn, strongUpEn, pinValue;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  qb_port dut_i (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrStrobe(wrStrobe),
    .sclFall(sclFall), .padIn(padIn), .driveLowEn(driveLowEn),
    .strongUpEn(strongUpEn), .pinValue(pinValue)
  );

  // {written byte, expected pull-downs, expected boost}
  localparam logic [23:0] Vecs [6] = '{
    {8'h00, 8'hFF, 8'h00},
    {8'hFF, 8'h00, 8'hFF},
    {8'hA5, 8'h5A, 8'hA5},
    {8'h5A, 8'hA5, 8'h5A},
    {8'h01, 8'hFE, 8'h01},
    {8'h80, 8'h7F, 8'h80}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic doWrite, input logic [7:0] d, input logic doFall);
    @(negedge clk);
    wrStrobe = doWrite; wrData = d; sclFall = doFall;
    @(negedge clk);
    wrStrobe = 1'b0; sclFall = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 driveLowEn", driveLowEn, 8'h00);
    check("R1 strongUpEn", strongUpEn, 8'h00);
    check("R1 pinValue", pinValue, 8'hFF);

    foreach (Vecs[i]) begin
      pulse(1'b1, Vecs[i][23:16], 1'b0);
      check("R2 drive after write", driveLowEn, Vecs[i][15:8]);
      check("R3 boost after write", strongUpEn, Vecs[i][7:0]);
      pulse(1'b0, 8'h00, 1'b1);
      check("R4 boost cleared", strongUpEn, 8'h00);
      check("R4 level kept", driveLowEn, Vecs[i][15:8]);
    end

    // R8: write and SCL fall together, write wins
    pulse(1'b1, 8'h0F, 1'b1);
    check("R8 boost kept", strongUpEn, 8'h0F);
    check("R8 drive", driveLowEn, 8'hF0);
    pulse(1'b0, 8'h00, 1'b1);
    check("R8 later fall clears", strongUpEn, 8'h00);

    // R5: rewriting ones re-arms the boost
    pulse(1'b1, 8'h0F, 1'b0);
    check("R5 boost re-armed", strongUpEn, 8'h0F);
    check("R6 no overlap", driveLowEn & strongUpEn, 8'h00);
    pulse(1'b0, 8'h00, 1'b1);

    // R9: data without a strobe is ignored
    pulse(1'b0, 8'hFF, 1'b0);
    check("R9 drive unchanged", driveLowEn, 8'hF0);
    check("R9 boost unchanged", strongUpEn, 8'h00);

    // R7: read follows the pad, not the stored bits, after two edges
    @(negedge clk);
    padIn = 8'h3C;
    @(negedge clk);
    check("R7 one edge early", pinValue, 8'hFF);
    @(negedge clk);
    check("R7 pad value", pinValue, 8'h3C);

    // R1: reset again restores the defaults
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset drive", driveLowEn, 8'h00);
    check("R1 reset boost", strongUpEn, 8'h00);
    rstN = 1'b1;

    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule